// File: doc/BRIEF.md
# Dithered Phase Accumulator for a Digital Sine Synthesizer

This block is the phase engine of a digital waveform synthesizer. A wide phase register advances by a programmable tuning word on every accepted step and wraps modulo 2^PH_W. The output frequency is therefore tuning·f_clk / 2^PH_W. A programmable phase offset is added to the running phase. An optional small pseudo-random term is added just below the truncation point. The sum is then cut down to a short OUT_W-bit phase word, which addresses a downstream amplitude table.

Software-side logic first writes the tuning word and the offset into holding registers. A single update strobe then moves both into service on the same clock. Because the accumulator keeps its value across an update, frequency changes never cause a phase jump.

The phase word leaves the block as a valid/ready stream. A step takes place only when the enable is high and the output register is free, meaning either empty or being accepted by the consumer. While the consumer holds ready low, the sample, the accumulator and the noise generator all freeze, so no sample is lost or skipped.

Top module: `nco_dither_core`

## Requirements
- R1: A step happens on a clock edge where `en` is high and either `phase_vld` is low or `phase_rdy` is high. On each step the accumulator gains the active tuning word. With dither off, the n-th sample after reset (n from 0) equals the top OUT_W bits of (n·tune + offset) mod 2^PH_W.
- R2: The accumulator wraps modulo 2^PH_W and is never cleared at the wrap point. For example, with tune 0x4000_0000 and offset 0x8000_0000 the samples run 0x800, 0xC00, 0x000, 0x400, 0x800.
- R3: The active offset is added to the accumulator before truncation. The sample is bits [PH_W-1:PH_W-OUT_W] of the sum, which are bits 31:20 by default.
- R4: A one-cycle pulse on `ld_tune` or `ld_offs` copies `wr_data` into a holding register and has no effect on the output. A pulse on `upd` moves both holding values into service together. A step on the same edge as `upd` still uses the previous values.
- R5: An update does not alter the accumulator, so the phase sequence continues from where it stood. The accumulator also holds on every cycle without a step.
- R6: When `dith_en` is high at a step, the low DITH_W bits of the noise register are added at bit position PH_W-OUT_W-DITH_W (bits 19:18 by default). When `dith_en` is low, no noise is added.
- R7: The noise register is a 16-bit Fibonacci shift register with polynomial x^16+x^14+x^13+x^11+1. It shifts left with new bit0 = s15^s13^s12^s10, starts at 0xACE1 after reset, and advances exactly once per step whatever the value of `dith_en`.
- R8: `phase_vld` is high in the cycle after any step. While `phase_vld` is high and `phase_rdy` is low, the sample stays unchanged and nothing advances. When no step occurs and the consumer is ready, `phase_vld` falls on the next edge.
- R9: Synchronous active-high `rst` clears the accumulator, the holding and active registers, `phase_o` and `phase_vld`, and reseeds the noise register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Run enable; a step needs this high |
| ld_tune | input | 1 | Load `wr_data` into the tuning holding register |
| ld_offs | input | 1 | Load `wr_data` into the offset holding register |
| wr_data | input | PH_W | Write data for both holding registers |
| upd | input | 1 | Move both holding values into service |
| dith_en | input | 1 | Add pseudo-random term below the truncation point |
| phase_rdy | input | 1 | Consumer accepts the current sample |
| phase_o | output | OUT_W | Truncated phase word |
| phase_vld | output | 1 | `phase_o` holds a sample not yet accepted |

## Verification
The assertions take for granted that the control inputs carry no unknown values once reset is released. They also assume that `ld_tune`, `ld_offs` and `upd` are treated as single-cycle events. Note that `en` and `phase_rdy` may change in any cycle, including while a sample is stalled. The stimulus drives every input on the falling edge and pulses the load and update lines for exactly one cycle. It holds `rst` high from time zero so that the reset property's first sample is defined.

// File: rtl/nco_pkg.sv
package nco_pkg;
  localparam int unsigned LFSR_W = 16;
  localparam logic [LFSR_W-1:0] LFSR_SEED = 16'hACE1;

  function automatic logic [LFSR_W-1:0] lfsr_next(input logic [LFSR_W-1:0] s);
    return {s[LFSR_W-2:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
  endfunction
endpackage

// File: rtl/nco_lfsr.sv
module nco_lfsr
  import nco_pkg::*;
#(
  parameter int unsigned DITH_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              adv,
  output logic [DITH_W-1:0] noise
);
  logic [LFSR_W-1:0] state_q;

  always_ff @(posedge clk) begin
    if (rst)      state_q <= LFSR_SEED;
    else if (adv) state_q <= lfsr_next(state_q);
  end

  assign noise = state_q[DITH_W-1:0];
endmodule

// File: rtl/nco_shadow.sv
module nco_shadow #(
  parameter int unsigned PH_W = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            ld_tune,
  input  logic            ld_offs,
  input  logic [PH_W-1:0] wr_data,
  input  logic            upd,
  output logic [PH_W-1:0] tune_act,
  output logic [PH_W-1:0] offs_act
);
  logic [PH_W-1:0] tune_hold, offs_hold;

  always_ff @(posedge clk) begin
    if (rst) begin
      tune_hold <= '0;
      offs_hold <= '0;
      tune_act  <= '0;
      offs_act  <= '0;
    end else begin
      if (ld_tune) tune_hold <= wr_data;
      if (ld_offs) offs_hold <= wr_data;
      if (upd) begin
        tune_act <= tune_hold;
        offs_act <= offs_hold;
      end
    end
  end
endmodule

// File: rtl/nco_accum.sv
module nco_accum #(
  parameter int unsigned PH_W = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            step,
  input  logic [PH_W-1:0] tune,
  output logic [PH_W-1:0] acc
);
  always_ff @(posedge clk) begin
    if (rst)       acc <= '0;
    else if (step) acc <= acc + tune;
  end
endmodule

// File: rtl/nco_dither_core.sv
module nco_dither_core #(
  parameter int unsigned PH_W   = 32,
  parameter int unsigned OUT_W  = 12,
  parameter int unsigned DITH_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             ld_tune,
  input  logic             ld_offs,
  input  logic [PH_W-1:0]  wr_data,
  input  logic             upd,
  input  logic             dith_en,
  input  logic             phase_rdy,
  output logic [OUT_W-1:0] phase_o,
  output logic             phase_vld
);
  localparam int unsigned CUT_W = PH_W - OUT_W;
  localparam int unsigned DPOS  = CUT_W - DITH_W;

  logic              step;
  logic [PH_W-1:0]   tune_act, offs_act, acc_q, noise_ext, sum;
  logic [DITH_W-1:0] noise;

  assign step = en && (!phase_vld || phase_rdy);

  nco_shadow #(.PH_W(PH_W)) u_shadow (
    .clk(clk), .rst(rst), .ld_tune(ld_tune), .ld_offs(ld_offs),
    .wr_data(wr_data), .upd(upd), .tune_act(tune_act), .offs_act(offs_act)
  );

  nco_accum #(.PH_W(PH_W)) u_accum (
    .clk(clk), .rst(rst), .step(step), .tune(tune_act), .acc(acc_q)
  );

  nco_lfsr #(.DITH_W(DITH_W)) u_lfsr (
    .clk(clk), .rst(rst), .adv(step), .noise(noise)
  );

  generate
    if (DPOS > 0) begin : g_shift
      assign noise_ext = dith_en ? (PH_W'(noise) << DPOS) : '0;
    end else begin : g_flush
      assign noise_ext = dith_en ? PH_W'(noise) : '0;
    end
  endgenerate

  assign sum = acc_q + offs_act + noise_ext;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_o   <= '0;
      phase_vld <= 1'b0;
    end else if (step) begin
      phase_o   <= OUT_W'(sum >> CUT_W);
      phase_vld <= 1'b1;
    end else if (phase_rdy) begin
      phase_vld <= 1'b0;
    end
  end
endmodule

// File: rtl/nco_dither_core_chk.sv
module nco_dither_core_chk #(
  parameter int unsigned PH_W  = 32,
  parameter int unsigned OUT_W = 12
) (
  input logic             clk,
  input logic             rst,
  input logic             en,
  input logic             upd,
  input logic             phase_rdy,
  input logic             phase_vld,
  input logic [OUT_W-1:0] phase_o,
  input logic [PH_W-1:0]  tune_act,
  input logic [PH_W-1:0]  offs_act,
  input logic [PH_W-1:0]  acc
);
  a_r9_reset_clears: assert property (@(posedge clk)
    rst |=> (!phase_vld && phase_o == '0));

  a_r8_step_gives_valid: assert property (@(posedge clk) disable iff (rst)
    (en && (!phase_vld || phase_rdy)) |=> phase_vld);

  a_r8_stall_holds: assert property (@(posedge clk) disable iff (rst)
    (phase_vld && !phase_rdy) |=> (phase_vld && $stable(phase_o) && $stable(acc)));

  a_r8_idle_drops: assert property (@(posedge clk) disable iff (rst)
    (!en && (phase_rdy || !phase_vld)) |=> !phase_vld);

  a_r5_acc_holds: assert property (@(posedge clk) disable iff (rst)
    !(en && (!phase_vld || phase_rdy)) |=> $stable(acc));

  a_r4_active_holds: assert property (@(posedge clk) disable iff (rst)
    !upd |=> ($stable(tune_act) && $stable(offs_act)));
endmodule

bind nco_dither_core nco_dither_core_chk #(.PH_W(PH_W), .OUT_W(OUT_W)) u_chk (
  .clk(clk), .rst(rst), .en(en), .upd(upd), .phase_rdy(phase_rdy),
  .phase_vld(phase_vld), .phase_o(phase_o), .tune_act(tune_act),
  .offs_act(offs_act), .acc(acc_q)
);

// File: tb/sim_nco_dither_core.sv
module sim_nco_dither_core;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en = 1'b0, ld_tune = 1'b0, ld_offs = 1'b0, upd = 1'b0;
  logic dith_en = 1'b0, phase_rdy = 1'b1;
  logic [31:0] wr_data = '0;
  logic [11:0] phase_o;
  logic        phase_vld;

  int checks = 0, errs = 0;
  bit done = 1'b0;

  // bench model
  logic [31:0] macc, mtune, moffs, htune, hoffs;
  logic [15:0] mlfsr;
  logic [11:0] last;

  always #10 clk = ~clk;

  nco_dither_core u0 (
    .clk(clk), .rst(rst), .en(en), .ld_tune(ld_tune), .ld_offs(ld_offs),
    .wr_data(wr_data), .upd(upd), .dith_en(dith_en), .phase_rdy(phase_rdy),
    .phase_o(phase_o), .phase_vld(phase_vld)
  );

  // tune, offset, expected first sample (R1, R2, R3)
  localparam logic [95:0] VEC [0:3] = '{
    {32'h0010_0000, 32'h0000_0000, 32'h000},
    {32'h4000_0000, 32'h8000_0000, 32'h800},
    {32'h0000_0001, 32'hFFF0_0000, 32'hFFF},
    {32'hFFF0_0000, 32'h0123_4567, 32'h012}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [11:0] mexp();
    logic [31:0] s;
    s = macc + moffs + (dith_en ? ({30'b0, mlfsr[1:0]} << 18) : 32'd0);
    return s[31:20];
  endfunction

  function automatic void madv();
    macc  = macc + mtune;
    mlfsr = {mlfsr[14:0], mlfsr[15] ^ mlfsr[13] ^ mlfsr[12] ^ mlfsr[10]};
  endfunction

  task automatic do_reset();
    rst = 1'b1; en = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    macc = '0; mtune = '0; moffs = '0; htune = '0; hoffs = '0; mlfsr = 16'hACE1;
  endtask

  task automatic load(input logic [31:0] t, input logic [31:0] o, input bit apply);
    ld_tune = 1'b1; wr_data = t; @(negedge clk); ld_tune = 1'b0; htune = t;
    ld_offs = 1'b1; wr_data = o; @(negedge clk); ld_offs = 1'b0; hoffs = o;
    if (apply) begin
      upd = 1'b1; @(negedge clk); upd = 1'b0;
      mtune = htune; moffs = hoffs;
    end
  endtask

  // steps n times, checking each sample against the model
  task automatic run(input int n, input string tag);
    en = 1'b1; phase_rdy = 1'b1;
    for (int i = 0; i < n; i++) begin
      logic [11:0] e;
      e = mexp();
      @(negedge clk);
      chk(tag, {20'b0, phase_o}, {20'b0, e});
      chk(tag, {31'b0, phase_vld}, 32'd1);
      last = phase_o;
      madv();
    end
    en = 1'b0;
  endtask

  initial begin
    // R9: reset state
    do_reset();
    chk("R9", {20'b0, phase_o}, 32'd0);
    chk("R9", {31'b0, phase_vld}, 32'd0);

    // table walk: R1 R2 R3
    for (int v = 0; v < 4; v++) begin
      do_reset();
      load(VEC[v][95:64], VEC[v][63:32], 1'b1);
      en = 1'b1;
      @(negedge clk);
      chk("R3", {20'b0, phase_o}, VEC[v][31:0]);
      madv();
      run(6, "R1");
    end

    // R2: wrap with period 4
    do_reset();
    load(32'hC000_0000, 32'h0, 1'b1);
    run(9, "R2");

    // R4 / R5: holding registers and phase continuity
    do_reset();
    load(32'h0100_0000, 32'h0, 1'b1);
    run(3, "R1");
    @(negedge clk);
    chk("R8", {31'b0, phase_vld}, 32'd0);
    chk("R8", {20'b0, phase_o}, {20'b0, last});
    load(32'h0000_1000, 32'h0040_0000, 1'b0);
    run(2, "R4");
    upd = 1'b1; @(negedge clk); upd = 1'b0;
    mtune = htune; moffs = hoffs;
    run(3, "R5");

    // R4: step on the same edge as the update uses old values
    load(32'h2000_0000, 32'h0, 1'b0);
    begin
      logic [11:0] e;
      e = mexp();
      en = 1'b1; upd = 1'b1;
      @(negedge clk);
      upd = 1'b0;
      chk("R4", {20'b0, phase_o}, {20'b0, e});
      madv();
      mtune = htune; moffs = hoffs;
    end
    run(4, "R5");

    // R8: back-pressure stall
    run(1, "R8");
    en = 1'b1; phase_rdy = 1'b0;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk("R8", {20'b0, phase_o}, {20'b0, last});
      chk("R8", {31'b0, phase_vld}, 32'd1);
    end
    run(4, "R8");

    // R6 / R7: dither on and off
    do_reset();
    dith_en = 1'b1;
    load(32'h0004_0000, 32'h000F_FFFF, 1'b1);
    run(24, "R6");
    do_reset();
    dith_en = 1'b1;
    load(32'h0, 32'h000F_FFFF, 1'b1);
    run(20, "R7");
    do_reset();
    dith_en = 1'b0;
    load(32'h0, 32'h000F_FFFF, 1'b1);
    run(6, "R6");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    #(20 * 20000);
    if (!done) begin
      checks++; errs++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end
endmodule